// File: doc/BRIEF.md
# Vertical-Blank Synchronised Configuration Latch

This block is a small display timing helper. A horizontal pixel counter and a vertical line counter step through each frame. The frame size comes from timing inputs. From the counters the block derives a vertical-blank flag and a one-cycle vertical sync pulse. It also derives three one-cycle global sync pulses: a startup pulse, an update pulse and a ready pulse. Each of these three sits on a programmable line of the blanking interval. Its position does not depend on the vertical sync line.

The second part is a bank of double-buffered configuration registers, for example a surface base address and a few plane parameters. Software can write the pending copy of any register at any moment, as often as it likes. The active copies, which drive the downstream pipeline, all reload together on the update pulse. Only the last value written before that pulse takes effect. A frame-event output fires together with the update pulse, so software can use it as its flip-complete or vertical-blank interrupt.

Top module: `vblank_dbuf_regs`

## Requirements
- R1: The pixel counter counts 0 to `h_total_i`-1 and then wraps. The line counter advances when the pixel counter wraps and counts 0 to `v_total_i`-1. `vblank_o` is 1 exactly when the line counter is at or above `v_active_i`.
- R2: `vsync_o` is high for one clock, when the line counter equals `vsync_line_i` and the pixel counter is 0.
- R3: When the configuration is valid, each of `startup_o`, `update_o` and `ready_o` is high for one clock. That clock is the one where the line counter equals that pulse's own line input and the pixel counter is 0.
- R4: The configuration is valid only when `v_active_i` <= startup line < update line < ready line < `v_total_i`. Otherwise `cfg_err_o` is 1 and all three global sync pulses stay low.
- R5: At most one of the three global sync pulses is high in any cycle, and each of them fires only during vertical blank.
- R6: On an update pulse, every active register takes its pending value in the same clock. The new values appear on `active_regs_o` one cycle after the pulse.
- R7: A write with `wr_en_i` high stores `wr_data_i` into the pending copy selected by `wr_idx_i`. When several writes reach the same register between two update pulses, only the last one becomes active.
- R8: A write in the same cycle as an update pulse goes to the pending copy only. It becomes active at the following update pulse.
- R9: `frame_evt_o` is high in exactly the cycles where `update_o` is high.
- R10: While reset is held, both counters are 0 and all pending and active registers are 0. Register i occupies bits [32*i+31 : 32*i] of `active_regs_o`.
- R11: `active_regs_o` does not change in any cycle that is not the one right after an update pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Pixel clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| h_total_i | input | 12 | Pixels per line, blanking included |
| v_total_i | input | 12 | Lines per frame, blanking included |
| v_active_i | input | 12 | Visible lines; the blank interval starts at this line |
| vsync_line_i | input | 12 | Line that carries the vertical sync pulse |
| startup_line_i | input | 12 | Line of the startup pulse |
| update_line_i | input | 12 | Line of the update pulse |
| ready_line_i | input | 12 | Line of the ready pulse |
| wr_en_i | input | 1 | Pending register write strobe |
| wr_idx_i | input | 2 | Index of the register being written |
| wr_data_i | input | 32 | Write data |
| startup_o | output | 1 | Startup global sync pulse |
| update_o | output | 1 | Update global sync pulse; the active registers load on it |
| ready_o | output | 1 | Ready global sync pulse |
| vblank_o | output | 1 | Vertical blank flag |
| vsync_o | output | 1 | Vertical sync pulse |
| frame_evt_o | output | 1 | Frame event for software, coincident with the update pulse |
| cfg_err_o | output | 1 | Global sync line placement is invalid |
| active_regs_o | output | 128 | Active register copies, concatenated by index |

## Verification
The assertions assume the frame timing inputs are stable and non-zero, with `h_total_i` of at least 1 and `v_active_i` below `v_total_i`. Under that assumption the counter ranges and the in-blank placement of the pulses can be judged. The bench holds the frame size fixed for the whole run and changes only the three sync line inputs. It changes them at line boundaries well away from the pulses, which covers both valid placements and several kinds of invalid placement. Writes are driven freely: inside and outside blank, in bursts to one register, and on the exact update cycle.

// File: rtl/vbdb_pkg.sv
package vbdb_pkg;
  typedef struct packed {
    logic startup;
    logic update;
    logic ready;
  } gsync_t;
endpackage

// File: rtl/vbdb_timing.sv
module vbdb_timing #(
  parameter int H_W = 12,
  parameter int V_W = 12
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic [H_W-1:0] h_total_i,
  input  logic [V_W-1:0] v_total_i,
  input  logic [V_W-1:0] v_active_i,
  input  logic [V_W-1:0] vsync_line_i,
  output logic [H_W-1:0] h_cnt_o,
  output logic [V_W-1:0] v_cnt_o,
  output logic           vblank_o,
  output logic           vsync_o
);
  logic h_last, v_last;

  assign h_last = (h_cnt_o >= h_total_i - H_W'(1));
  assign v_last = (v_cnt_o >= v_total_i - V_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      h_cnt_o <= '0;
      v_cnt_o <= '0;
    end else if (h_last) begin
      h_cnt_o <= '0;
      v_cnt_o <= v_last ? '0 : v_cnt_o + V_W'(1);
    end else begin
      h_cnt_o <= h_cnt_o + H_W'(1);
    end
  end

  assign vblank_o = (v_cnt_o >= v_active_i);
  assign vsync_o  = (v_cnt_o == vsync_line_i) && (h_cnt_o == '0);

  // timing inputs assumed static and non-zero
  p_hcnt_range_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    h_cnt_o < h_total_i);
  p_vcnt_range_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    v_cnt_o < v_total_i);
  p_line_step_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (h_cnt_o != '0) |-> $stable(v_cnt_o));
  p_vsync_single_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vsync_o |=> !vsync_o);
endmodule

// File: rtl/vbdb_sync_gen.sv
module vbdb_sync_gen
  import vbdb_pkg::*;
#(
  parameter int H_W = 12,
  parameter int V_W = 12
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic [H_W-1:0] h_cnt_i,
  input  logic [V_W-1:0] v_cnt_i,
  input  logic [V_W-1:0] v_total_i,
  input  logic [V_W-1:0] v_active_i,
  input  logic [V_W-1:0] startup_line_i,
  input  logic [V_W-1:0] update_line_i,
  input  logic [V_W-1:0] ready_line_i,
  output gsync_t         gsync_o,
  output logic           cfg_err_o
);
  logic cfg_ok, line_start;

  assign cfg_ok = (startup_line_i >= v_active_i) &&
                  (startup_line_i < update_line_i) &&
                  (update_line_i < ready_line_i) &&
                  (ready_line_i < v_total_i);
  assign cfg_err_o  = !cfg_ok;
  assign line_start = (h_cnt_i == '0);

  always_comb begin
    gsync_o.startup = cfg_ok && line_start && (v_cnt_i == startup_line_i);
    gsync_o.update  = cfg_ok && line_start && (v_cnt_i == update_line_i);
    gsync_o.ready   = cfg_ok && line_start && (v_cnt_i == ready_line_i);
  end

  p_no_overlap_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones({gsync_o.startup, gsync_o.update, gsync_o.ready}) <= 1);
  p_in_blank_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gsync_o.startup || gsync_o.update || gsync_o.ready) |-> (v_cnt_i >= v_active_i));
  p_err_quiet_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_err_o |-> !(gsync_o.startup || gsync_o.update || gsync_o.ready));
  p_upd_single_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gsync_o.update |=> !gsync_o.update);
endmodule

// File: rtl/vbdb_reg_bank.sv
module vbdb_reg_bank #(
  parameter int NUM_REGS = 4,
  parameter int DATA_W   = 32,
  localparam int IDX_W   = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       load_i,
  input  logic                       wr_en_i,
  input  logic [IDX_W-1:0]           wr_idx_i,
  input  logic [DATA_W-1:0]          wr_data_i,
  output logic [NUM_REGS*DATA_W-1:0] active_o
);
  logic [NUM_REGS*DATA_W-1:0] pending;

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
    logic sel;
    assign sel = wr_en_i && (wr_idx_i == IDX_W'(i));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)  pending[i*DATA_W +: DATA_W] <= '0;
      else if (sel) pending[i*DATA_W +: DATA_W] <= wr_data_i;
    end

    // load reads the old pending value, so a same-cycle write waits a frame
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     active_o[i*DATA_W +: DATA_W] <= '0;
      else if (load_i) active_o[i*DATA_W +: DATA_W] <= pending[i*DATA_W +: DATA_W];
    end
  end

  p_active_hold_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i |=> $stable(active_o));
  p_atomic_load_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> (active_o == $past(pending)));
endmodule

// File: rtl/vblank_dbuf_regs.sv
module vblank_dbuf_regs
  import vbdb_pkg::*;
#(
  parameter int H_W      = 12,
  parameter int V_W      = 12,
  parameter int NUM_REGS = 4,
  parameter int DATA_W   = 32,
  localparam int IDX_W   = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic [H_W-1:0]             h_total_i,
  input  logic [V_W-1:0]             v_total_i,
  input  logic [V_W-1:0]             v_active_i,
  input  logic [V_W-1:0]             vsync_line_i,
  input  logic [V_W-1:0]             startup_line_i,
  input  logic [V_W-1:0]             update_line_i,
  input  logic [V_W-1:0]             ready_line_i,
  input  logic                       wr_en_i,
  input  logic [IDX_W-1:0]           wr_idx_i,
  input  logic [DATA_W-1:0]          wr_data_i,
  output logic                       startup_o,
  output logic                       update_o,
  output logic                       ready_o,
  output logic                       vblank_o,
  output logic                       vsync_o,
  output logic                       frame_evt_o,
  output logic                       cfg_err_o,
  output logic [NUM_REGS*DATA_W-1:0] active_regs_o
);
  logic [H_W-1:0] h_cnt;
  logic [V_W-1:0] v_cnt;
  gsync_t         gsync;

  vbdb_timing #(.H_W(H_W), .V_W(V_W)) u_timing (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .h_total_i    (h_total_i),
    .v_total_i    (v_total_i),
    .v_active_i   (v_active_i),
    .vsync_line_i (vsync_line_i),
    .h_cnt_o      (h_cnt),
    .v_cnt_o      (v_cnt),
    .vblank_o     (vblank_o),
    .vsync_o      (vsync_o)
  );

  vbdb_sync_gen #(.H_W(H_W), .V_W(V_W)) u_sync (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .h_cnt_i        (h_cnt),
    .v_cnt_i        (v_cnt),
    .v_total_i      (v_total_i),
    .v_active_i     (v_active_i),
    .startup_line_i (startup_line_i),
    .update_line_i  (update_line_i),
    .ready_line_i   (ready_line_i),
    .gsync_o        (gsync),
    .cfg_err_o      (cfg_err_o)
  );

  vbdb_reg_bank #(.NUM_REGS(NUM_REGS), .DATA_W(DATA_W)) u_bank (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    (gsync.update),
    .wr_en_i   (wr_en_i),
    .wr_idx_i  (wr_idx_i),
    .wr_data_i (wr_data_i),
    .active_o  (active_regs_o)
  );

  assign startup_o   = gsync.startup;
  assign update_o    = gsync.update;
  assign ready_o     = gsync.ready;
  assign frame_evt_o = gsync.update;

  p_evt_with_upd_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_evt_o == update_o);
  p_upd_in_blank_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    update_o |-> vblank_o);
endmodule

// File: tb/vblank_dbuf_regs_tb_top.sv
module vblank_dbuf_regs_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int HT = 8, VT = 12, VA = 6;

  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic [11:0]  h_total_i = 12'(HT), v_total_i = 12'(VT), v_active_i = 12'(VA);
  logic [11:0]  vsync_line_i = 12'd8;
  logic [11:0]  startup_line_i = 12'd7, update_line_i = 12'd9, ready_line_i = 12'd10;
  logic         wr_en_i = 1'b0;
  logic [1:0]   wr_idx_i = '0;
  logic [31:0]  wr_data_i = '0;
  logic         startup_o, update_o, ready_o, vblank_o, vsync_o, frame_evt_o, cfg_err_o;
  logic [127:0] active_regs_o;

  int errors = 0, checks = 0;
  bit done = 0;
  int hc = 0, vc = 0;
  logic [31:0] pend [4];
  logic [31:0] act  [4];

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  vblank_dbuf_regs dut_i (.*);

  task automatic chk(input bit ok, input string req, input logic [127:0] a, input logic [127:0] e);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h (line %0d pix %0d)", req, a, e, vc, hc);
    end
  endtask

  function automatic logic [127:0] exp_act();
    logic [127:0] v;
    for (int i = 0; i < 4; i++) v[i*32 +: 32] = act[i];
    return v;
  endfunction

  // one cycle: drive, compare against model, advance model
  task automatic step(input bit we, input int idx, input logic [31:0] d);
    bit ok, es, eu, er;
    int s, u, r;
    wr_en_i = we; wr_idx_i = 2'(idx); wr_data_i = d;
    #1;
    s = int'(startup_line_i); u = int'(update_line_i); r = int'(ready_line_i);
    ok = (s >= VA) && (s < u) && (u < r) && (r < VT);
    es = ok && hc == 0 && vc == s;
    eu = ok && hc == 0 && vc == u;
    er = ok && hc == 0 && vc == r;
    chk(vblank_o == (vc >= VA), "R1 vblank", 128'(vblank_o), 128'(vc >= VA));
    chk(vsync_o == (hc == 0 && vc == int'(vsync_line_i)), "R2 vsync", 128'(vsync_o),
        128'(hc == 0 && vc == int'(vsync_line_i)));
    chk(startup_o == es, "R3 startup", 128'(startup_o), 128'(es));
    chk(update_o == eu, "R3 update", 128'(update_o), 128'(eu));
    chk(ready_o == er, "R3 ready", 128'(ready_o), 128'(er));
    chk(cfg_err_o == !ok, "R4 cfg_err", 128'(cfg_err_o), 128'(!ok));
    chk(frame_evt_o == eu, "R9 frame_evt", 128'(frame_evt_o), 128'(eu));
    chk(active_regs_o == exp_act(), "R6/R7/R8/R11 active", active_regs_o, exp_act());
    if (eu) for (int i = 0; i < 4; i++) act[i] = pend[i];
    if (we) pend[idx] = d;
    if (hc == HT - 1) begin
      hc = 0;
      vc = (vc == VT - 1) ? 0 : vc + 1;
    end else hc++;
    @(negedge clk_i);
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) step(1'b0, 0, '0);
  endtask

  task automatic run_to(input int line, input int pix);
    while (!(vc == line && hc == pix)) step(1'b0, 0, '0);
  endtask

  initial begin
    for (int i = 0; i < 4; i++) begin pend[i] = '0; act[i] = '0; end
    repeat (3) @(negedge clk_i);
    // R10: reset state
    chk(active_regs_o == '0, "R10 active zero", active_regs_o, '0);
    chk(vblank_o == 1'b0, "R10 counters at first active pixel", 128'(vblank_o), 0);
    chk(vsync_o == 1'b0 && update_o == 1'b0, "R10 no pulses", 128'({vsync_o, update_o}), 0);
    rst_ni = 1'b1;
    // frame with no writes: active stays zero (R11)
    idle(HT * VT);
    // R7 mailbox: several writes to reg0 in active region, last wins
    run_to(1, 2);
    step(1'b1, 0, 32'h1111_0000);
    step(1'b1, 0, 32'h2222_0000);
    step(1'b0, 0, '0);
    step(1'b1, 0, 32'h3333_0000);
    step(1'b1, 2, 32'hA5A5_0002);
    // write during blank before update still lands this frame
    run_to(8, 3);
    step(1'b1, 1, 32'hBEEF_0001);
    step(1'b1, 3, 32'hCAFE_0003);
    // R8: write on the exact update cycle
    run_to(9, 0);
    step(1'b1, 0, 32'h4444_0000);
    idle(HT * VT);
    // after update line: write reg1 twice across the frame (R7)
    run_to(2, 0);
    step(1'b1, 1, 32'h5555_0001);
    run_to(7, 4);
    step(1'b1, 1, 32'h6666_0001);
    idle(HT * VT);
    // R4: invalid placements, no pulses, writes stay pending
    run_to(3, 1);
    update_line_i = 12'd7; // equals startup
    step(1'b1, 2, 32'h7777_0002);
    idle(HT * VT + 5);
    run_to(3, 1);
    startup_line_i = 12'd5; update_line_i = 12'd9; // startup inside active lines
    idle(HT * VT);
    run_to(3, 1);
    startup_line_i = 12'd7; ready_line_i = 12'd12; // ready beyond frame
    idle(HT * VT);
    run_to(3, 1);
    ready_line_i = 12'd8; // out of order
    idle(HT * VT);
    // R3/R5 boundary placement: first blank line and last line
    run_to(3, 1);
    startup_line_i = 12'd6; update_line_i = 12'd7; ready_line_i = 12'd11;
    step(1'b1, 3, 32'h8888_0003);
    idle(2 * HT * VT);
    // burst of writes to every register every cycle across an update
    run_to(6, 5);
    for (int k = 0; k < 40; k++) step(1'b1, k % 4, 32'h9000_0000 + k);
    idle(2 * HT * VT);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule